// File: doc/BRIEF.md
# Processor Core Power-Up Sequencer

This block takes one processor core out of power collapse. A single start pulse begins the sequence. The block first asks for the core supply rail and waits for the rail to acknowledge. It then lets the rail settle. After that it walks a 9-bit power-control word through a fixed series of clamp and reset release steps. Each step holds for at least a minimum number of clock cycles before the next one begins.

Every dwell time is given in nanoseconds. It becomes a cycle count when the design is elaborated, computed from a clock-frequency parameter and rounded up, so a wait is never shorter than it should be. When the sequence finishes, the control word keeps the core marked as powered. The block then sits still until it is reset.

Top module: `core_pwrup_seq`

## Requirements
- R1: After a synchronous reset, the control word is all-zero, and railEn, busy and done are all low.
- R2: In the cycle after a start pulse taken in the idle state, railEn and busy go high. The control word stays all-zero for as long as railAck stays low.
- R3: After railAck is seen, the word stays zero for ceil(512 us × CLK_HZ) cycles. It then becomes 0x109, which is the PLL clamp (bit 8), L2 data sleep (bit 3) and I/O clamp (bit 0).
- R4: The word 0x109 holds for one cycle. It is followed by 0x101 (L2 data sleep cleared), which holds for ceil(300 ns × CLK_HZ) cycles.
- R5: The word 0x121 (power-on reset, bit 5, asserted) then holds for ceil(2 us × CLK_HZ) cycles.
- R6: The word 0x120 (I/O clamp released, reset still held) then holds for ceil(2 us × CLK_HZ) cycles.
- R7: The word 0x100 (power-on reset released) then holds for ceil(100 us × CLK_HZ) cycles.
- R8: The word then becomes 0x180 (powered-up flag, bit 7, set) and keeps that value. In that same cycle, done is high for exactly one cycle and busy falls.
- R9: A start pulse that arrives while busy is high has no effect on the word values or on the step timing.
- R10: A start pulse that arrives after the sequence has completed leaves the word at 0x180 and busy low.
- R11: A reset in the middle of the sequence clears the word and railEn and returns the block to idle. A later start then runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle request to begin power-up |
| railAck | input | 1 | Core supply rail reports that it is ready |
| ctrlWord | output | 9 | Per-core power-control word |
| railEn | output | 1 | Request to turn on the core supply rail |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the powered-up flag is set |

## Verification
The bench measures the exact number of cycles that each word value is held, so it catches any dwell that is off by one. A counter that used N instead of N-1, or that skipped the one-cycle 0x109 step, would shift every later count.

A design that let the rail dwell begin before railAck, or that re-armed on a start pulse during the sequence, would show a shortened or restarted word trace. The bench also resets the block while the power-on reset bit is high, where a sticky bit would survive. It checks that done is a pulse and not a level.

// File: rtl/core_pwrup_pkg.sv
package core_pwrup_pkg;

  // Control word bit positions (consumed by the core power domain)
  localparam int unsigned BIT_PLL_CLAMP = 8;
  localparam int unsigned BIT_PWR_UP    = 7;
  localparam int unsigned BIT_CLK_GATE  = 6;
  localparam int unsigned BIT_POR       = 5;
  localparam int unsigned BIT_CORE_RST  = 4;
  localparam int unsigned BIT_L2_SLEEP  = 3;
  localparam int unsigned BIT_L1_RSTDIS = 2;
  localparam int unsigned BIT_MEM_CLAMP = 1;
  localparam int unsigned BIT_IO_CLAMP  = 0;
  localparam int unsigned WORD_W        = 9;

  // Dwell times in nanoseconds
  localparam longint unsigned NS_RAIL    = 64'd512_000;
  localparam longint unsigned NS_L2      = 64'd300;
  localparam longint unsigned NS_POR     = 64'd2_000;
  localparam longint unsigned NS_UNCLAMP = 64'd2_000;
  localparam longint unsigned NS_RELEASE = 64'd100_000;

  typedef enum logic [2:0] {
    STEP_PREP, STEP_L2, STEP_POR, STEP_UNCLAMP, STEP_RELEASE, STEP_UP
  } step_e;

  typedef enum logic [2:0] {
    DW_RAIL, DW_L2, DW_POR, DW_UNCLAMP, DW_RELEASE
  } dwell_e;

  typedef struct packed {
    logic   railOn;
    logic   wordLoad;
    step_e  wordSel;
    logic   cntLoad;
    dwell_e cntSel;
  } strobe_t;

  // Rounded-up cycle count, never below one
  function automatic longint unsigned nsToCycles(longint unsigned ns,
                                                  longint unsigned hz);
    longint unsigned r;
    r = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (r == 0) r = 1;
    return r;
  endfunction

  function automatic int unsigned widthFor(longint unsigned v);
    int unsigned w;
    w = 1;
    while ((64'd1 << w) <= v) w++;
    return w;
  endfunction

endpackage

// File: rtl/core_pwrup_ctrl.sv
module core_pwrup_ctrl
  import core_pwrup_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    railAck,
  input  logic    cntZero,
  output strobe_t stb,
  output logic    busy
);

  typedef enum logic [3:0] {
    S_IDLE, S_ACK, S_RAIL, S_PREP, S_L2, S_POR, S_UNCLAMP, S_RELEASE, S_UP
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext    = state;
    stb.railOn   = 1'b0;
    stb.wordLoad = 1'b0;
    stb.wordSel  = STEP_PREP;
    stb.cntLoad  = 1'b0;
    stb.cntSel   = DW_RAIL;
    unique case (state)
      S_IDLE: if (start) begin
        stateNext  = S_ACK;
        stb.railOn = 1'b1;
      end
      S_ACK: if (railAck) begin
        stateNext   = S_RAIL;
        stb.cntLoad = 1'b1;
        stb.cntSel  = DW_RAIL;
      end
      S_RAIL: if (cntZero) begin
        stateNext    = S_PREP;
        stb.wordLoad = 1'b1;
        stb.wordSel  = STEP_PREP;
      end
      S_PREP: begin
        stateNext    = S_L2;
        stb.wordLoad = 1'b1;
        stb.wordSel  = STEP_L2;
        stb.cntLoad  = 1'b1;
        stb.cntSel   = DW_L2;
      end
      S_L2: if (cntZero) begin
        stateNext    = S_POR;
        stb.wordLoad = 1'b1;
        stb.wordSel  = STEP_POR;
        stb.cntLoad  = 1'b1;
        stb.cntSel   = DW_POR;
      end
      S_POR: if (cntZero) begin
        stateNext    = S_UNCLAMP;
        stb.wordLoad = 1'b1;
        stb.wordSel  = STEP_UNCLAMP;
        stb.cntLoad  = 1'b1;
        stb.cntSel   = DW_UNCLAMP;
      end
      S_UNCLAMP: if (cntZero) begin
        stateNext    = S_RELEASE;
        stb.wordLoad = 1'b1;
        stb.wordSel  = STEP_RELEASE;
        stb.cntLoad  = 1'b1;
        stb.cntSel   = DW_RELEASE;
      end
      S_RELEASE: if (cntZero) begin
        stateNext    = S_UP;
        stb.wordLoad = 1'b1;
        stb.wordSel  = STEP_UP;
      end
      S_UP: stateNext = S_UP;
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE) && (state != S_UP);

endmodule

// File: rtl/core_pwrup_dpath.sv
module core_pwrup_dpath
  import core_pwrup_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned CYC_RAIL    = 4,
  parameter int unsigned CYC_L2      = 1,
  parameter int unsigned CYC_POR     = 1,
  parameter int unsigned CYC_UNCLAMP = 1,
  parameter int unsigned CYC_RELEASE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  output logic              cntZero,
  output logic [WORD_W-1:0] ctrlWord,
  output logic              railEn,
  output logic              done
);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cntInit;
  logic [WORD_W-1:0] wordNext;

  function automatic logic [WORD_W-1:0] bitOf(int unsigned pos);
    return WORD_W'(1) << pos;
  endfunction

  always_comb begin
    unique case (stb.cntSel)
      DW_RAIL:    cntInit = CNT_W'(CYC_RAIL - 1);
      DW_L2:      cntInit = CNT_W'(CYC_L2 - 1);
      DW_POR:     cntInit = CNT_W'(CYC_POR - 1);
      DW_UNCLAMP: cntInit = CNT_W'(CYC_UNCLAMP - 1);
      DW_RELEASE: cntInit = CNT_W'(CYC_RELEASE - 1);
      default:    cntInit = '0;
    endcase
  end

  always_comb begin
    unique case (stb.wordSel)
      STEP_PREP:    wordNext = bitOf(BIT_PLL_CLAMP) | bitOf(BIT_L2_SLEEP) | bitOf(BIT_IO_CLAMP);
      STEP_L2:      wordNext = bitOf(BIT_PLL_CLAMP) | bitOf(BIT_IO_CLAMP);
      STEP_POR:     wordNext = bitOf(BIT_PLL_CLAMP) | bitOf(BIT_POR) | bitOf(BIT_IO_CLAMP);
      STEP_UNCLAMP: wordNext = bitOf(BIT_PLL_CLAMP) | bitOf(BIT_POR);
      STEP_RELEASE: wordNext = bitOf(BIT_PLL_CLAMP);
      STEP_UP:      wordNext = bitOf(BIT_PLL_CLAMP) | bitOf(BIT_PWR_UP);
      default:      wordNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      ctrlWord <= '0;
      railEn   <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (stb.cntLoad)     cnt <= cntInit;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
      if (stb.wordLoad)    ctrlWord <= wordNext;
      if (stb.railOn)      railEn <= 1'b1;
      done <= stb.wordLoad && (stb.wordSel == STEP_UP);
    end
  end

  assign cntZero = (cnt == '0);

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
  import core_pwrup_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 64'd100_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       railAck,
  output logic [8:0] ctrlWord,
  output logic       railEn,
  output logic       busy,
  output logic       done
);

  localparam longint unsigned C_RAIL    = nsToCycles(NS_RAIL, CLK_HZ);
  localparam longint unsigned C_L2      = nsToCycles(NS_L2, CLK_HZ);
  localparam longint unsigned C_POR     = nsToCycles(NS_POR, CLK_HZ);
  localparam longint unsigned C_UNCLAMP = nsToCycles(NS_UNCLAMP, CLK_HZ);
  localparam longint unsigned C_RELEASE = nsToCycles(NS_RELEASE, CLK_HZ);
  localparam int unsigned     CNT_W     = widthFor(C_RAIL);

  strobe_t stb;
  logic    cntZero;

  core_pwrup_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .railAck (railAck),
    .cntZero (cntZero),
    .stb     (stb),
    .busy    (busy)
  );

  core_pwrup_dpath #(
    .CNT_W       (CNT_W),
    .CYC_RAIL    (int'(C_RAIL)),
    .CYC_L2      (int'(C_L2)),
    .CYC_POR     (int'(C_POR)),
    .CYC_UNCLAMP (int'(C_UNCLAMP)),
    .CYC_RELEASE (int'(C_RELEASE))
  ) i_dpath (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .cntZero  (cntZero),
    .ctrlWord (ctrlWord),
    .railEn   (railEn),
    .done     (done)
  );

endmodule

// File: rtl/core_pwrup_chk.sv
module core_pwrup_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       railAck,
  input logic [8:0] ctrlWord,
  input logic       railEn,
  input logic       busy,
  input logic       done
);

  logic prevRst = 1'b0;
  always_ff @(posedge clk) prevRst <= rst;

  always_ff @(posedge clk) begin
    if (prevRst)
      AST_RESET_CLEARS: assert (ctrlWord == 9'h000 && !railEn && !busy && !done); // R1
  end

  AST_RAIL_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> railEn); // R2

  AST_START_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ctrlWord == 9'h000); // R2

  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && ctrlWord != $past(ctrlWord) && $past(ctrlWord) != 9'h000)
      |-> $countones(ctrlWord ^ $past(ctrlWord)) == 1); // R5

  AST_DONE_WORD: assert property (@(posedge clk) disable iff (rst)
    done |-> (ctrlWord == 9'h180 && !busy)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_UP_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && ctrlWord[7]) |=> $stable(ctrlWord) && !busy); // R10

endmodule

bind core_pwrup_seq core_pwrup_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .railAck  (railAck),
  .ctrlWord (ctrlWord),
  .railEn   (railEn),
  .busy     (busy),
  .done     (done)
);

// File: tb/test_core_pwrup_seq.sv
module test_core_pwrup_seq;

  localparam int CLK_PERIOD = 10;
  localparam longint unsigned TB_HZ = 64'd10_000_000;
  localparam int RAIL_CYC = 5120;  // 512 us at 10 MHz
  localparam int N_STEPS  = 5;
  localparam logic [8:0] EXP_WORD [N_STEPS+1] =
    '{9'h109, 9'h101, 9'h121, 9'h120, 9'h100, 9'h180};
  localparam int EXP_HOLD [N_STEPS] = '{1, 3, 20, 20, 1000};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic railAck = 1'b0;
  logic [8:0] ctrlWord;
  logic railEn, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_pwrup_seq #(.CLK_HZ(TB_HZ)) i_core_pwrup_seq (
    .clk(clk), .rst(rst), .start(start), .railAck(railAck),
    .ctrlWord(ctrlWord), .railEn(railEn), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; railAck = 1'b0; start = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Runs from idle through completion, measuring every hold length
  task automatic runFull(input bit injectStart);
    int zeros;
    int hold;
    pulseStart();
    check(busy && railEn && ctrlWord == 9'h000, "R2 start",
          {busy, railEn, ctrlWord}, {2'b11, 9'h000});
    repeat (40) @(negedge clk);
    check(ctrlWord == 9'h000 && busy, "R2 no ack", ctrlWord, 0);
    railAck = 1'b1;
    zeros = 0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (ctrlWord != 9'h000) break;
      zeros++;
    end
    check(zeros == RAIL_CYC, "R3 rail dwell", zeros, RAIL_CYC);
    check(ctrlWord == EXP_WORD[0], "R3 first word", ctrlWord, EXP_WORD[0]);
    for (int i = 0; i < N_STEPS; i++) begin
      check(ctrlWord == EXP_WORD[i], (i == 0) ? "R4 word" : (i < 3) ? "R5 word" :
            (i == 3) ? "R6 word" : "R7 word", ctrlWord, EXP_WORD[i]);
      hold = 1;
      for (int k = 0; k < 5000; k++) begin
        if (injectStart && i == 2 && hold == 5) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (ctrlWord != EXP_WORD[i]) break;
        hold++;
      end
      case (i)
        0, 1: check(hold == EXP_HOLD[i], injectStart ? "R4 R9 hold" : "R4 hold", hold, EXP_HOLD[i]);
        2:    check(hold == EXP_HOLD[i], injectStart ? "R5 R9 hold" : "R5 hold", hold, EXP_HOLD[i]);
        3:    check(hold == EXP_HOLD[i], "R6 hold", hold, EXP_HOLD[i]);
        default: check(hold == EXP_HOLD[i], "R7 hold", hold, EXP_HOLD[i]);
      endcase
    end
    check(ctrlWord == 9'h180 && done && !busy, "R8 final",
          {done, busy, ctrlWord}, {2'b10, 9'h180});
    @(negedge clk);
    check(ctrlWord == 9'h180 && !done, "R8 done pulse", {done, ctrlWord}, {1'b0, 9'h180});
  endtask

  initial begin
    doReset();
    check(ctrlWord == 9'h000 && !railEn && !busy && !done, "R1 reset",
          {railEn, busy, done, ctrlWord}, 0);

    runFull(1'b0);

    // R10: start after completion
    pulseStart();
    repeat (30) @(negedge clk);
    check(ctrlWord == 9'h180 && !busy, "R10 restart ignored", {busy, ctrlWord}, 9'h180);

    // R11: reset while power-on reset bit is asserted
    doReset();
    pulseStart();
    railAck = 1'b1;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (ctrlWord == 9'h121) break;
    end
    check(ctrlWord == 9'h121, "R11 reached reset step", ctrlWord, 9'h121);
    rst = 1'b1; railAck = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check(ctrlWord == 9'h000 && !railEn && !busy && !done, "R11 mid reset",
          {railEn, busy, ctrlWord}, 0);
    repeat (10) @(negedge clk);
    check(ctrlWord == 9'h000 && !busy, "R11 stays idle", {busy, ctrlWord}, 0);

    // R9 and R11: full rerun with a start pulse injected while busy
    runFull(1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule